// File: doc/BRIEF.md
# SPI Master Burst Exchange Engine

This block drives one SPI master link in mode 0. It has a transmit FIFO and a receive FIFO of 32-bit words. Software or an upstream agent loads words into the transmit FIFO and programs a burst length in bits. It then pulses a start input. The engine takes words from the transmit FIFO and shifts their bytes out on MOSI. It collects the MISO bytes into 32-bit receive words and stores them in the receive FIFO.

The programmed bit count is rounded up to whole bytes. A burst longer than 32 bits is split into words. The first word carries only the part of the count left over after whole 32-bit words, and every later word carries a full 32 bits. In single-burst mode the exchange stops when the burst count runs out. In multi-burst mode the engine reloads the count and keeps going until the transmit FIFO is empty. Either way the busy bit drops and the done flag rises.

Both word interfaces use valid/ready handshakes:
- A transmit word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the transmit FIFO is full.
- `rx_valid` is high while the receive FIFO holds data. `rx_data` shows the oldest word. That word is removed on an edge where `rx_ready` is also high, and `rx_data` stays stable while `rx_valid` is held without `rx_ready`.

Top module: `spi_burst_xchg`

## Requirements
- R1: The burst carries `cfg_burst_len`+1 bits rounded up to the next multiple of 8. For example, a field of 11 gives 16 bits (two bytes on the wire).
- R2: Each word taken from the transmit FIFO carries (remaining burst bits mod 32) bits, or 32 bits when that remainder is 0. A 40-bit burst therefore sends 8 bits from its first word and 32 from its second.
- R3: For a word carrying N bits, bytes go out starting with bits [N-1:N-8] and moving down to bits [7:0]. Each byte is sent MSB first. The word's bits above N are not sent.
- R4: Each received byte enters the receive word at its low end, so earlier bytes end in higher bits and unused upper bits are 0. The whole word is stored in the receive FIFO.
- R5: A word that completes while the receive FIFO is full is dropped. `rx_overflow` is then set and stays set until reset.
- R6: With `cfg_multi` low, the exchange stops when the remaining burst count reaches 0: `xfer_done` is set and `xch_busy` is cleared. Transmit words not yet used stay queued for the next start.
- R7: When a word ends with the transmit FIFO empty, or a started exchange finds it empty, `xfer_done` is set and `xch_busy` is cleared.
- R8: With `cfg_multi` high, a burst count that reaches 0 is reloaded from `cfg_burst_len` at the next word. The split rule of R2 restarts with each burst.
- R9: SCLK idles low. MOSI changes only while SCLK is low and is stable while SCLK is high. MISO is sampled as SCLK rises.
- R10: `tx_ready` is low while the transmit FIFO holds FIFO_DEPTH words, and a word offered then is not accepted. `rx_valid` is high exactly while the receive FIFO is non-empty, and `rx_data` holds while it waits.
- R11: After reset, `xch_busy`, `xfer_done`, `rx_overflow`, `rx_valid` and `sclk` are 0 and `tx_ready` is 1.
- R12: A `xch_start` pulse sets `xch_busy` and clears `xfer_done` on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | BURST_W | Burst length in bits minus one |
| cfg_multi | input | 1 | Continue across bursts while transmit data remains |
| xch_start | input | 1 | One-cycle pulse that starts an exchange |
| xch_busy | output | 1 | Exchange in progress; drops when the engine stops |
| xfer_done | output | 1 | Transfer complete flag |
| rx_overflow | output | 1 | Sticky flag for a receive word that was dropped |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit FIFO can accept a word |
| tx_data | input | 32 | Transmit word |
| rx_valid | output | 1 | Receive word available |
| rx_ready | input | 1 | Consumer takes the receive word |
| rx_data | output | 32 | Oldest receive word |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Faults in the remaining-bit counter or the byte pointer show up at MOSI within the same word. The wire sends the wrong byte first or the wrong number of bytes, and the MOSI scoreboard flags this at the next SCLK rising edge. Faults in receive assembly or overflow handling show up at the next receive-FIFO pop or in the flag state after the exchange. MISO is looped back inverted, so every received word has a value that can be predicted. A stop decision taken on the wrong condition shows up as an early or late fall of `xch_busy`. It also shows up as bytes sent from a word that should have stayed queued.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_STORE
  } ctrl_state_e;
endpackage

// File: rtl/sbx_fifo.sv
module sbx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             do_push, do_pop;

  assign in_ready  = (count != FULL_CNT);
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sbx_shifter.sv
module sbx_shifter #(
  parameter int SCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       done,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(SCLK_HALF - 1);

  logic [CW-1:0] div_cnt;
  logic          active;
  logic [7:0]    tx_sr, rx_sr;
  logic [2:0]    bit_cnt;
  logic          tick;

  assign tick    = active && (div_cnt == DIV_LAST);
  assign rx_byte = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      active  <= 1'b0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      bit_cnt <= '0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        tx_sr   <= tx_byte;
        mosi    <= tx_byte[7];
        div_cnt <= '0;
        bit_cnt <= '0;
        sclk    <= 1'b0;
      end else if (active) begin
        if (tick) begin
          div_cnt <= '0;
          if (!sclk) begin
            sclk  <= 1'b1;
            rx_sr <= {rx_sr[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_cnt == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              mosi    <= tx_sr[6];
              tx_sr   <= {tx_sr[6:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sbx_ctrl.sv
module sbx_ctrl
  import spi_burst_pkg::*;
#(
  parameter int BURST_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BURST_W-1:0] burst_m1,
  input  logic               multi,
  input  logic               start,
  input  logic               tx_avail,
  input  logic [WORD_W-1:0]  tx_word,
  output logic               tx_take,
  input  logic               rx_space,
  output logic               rx_put,
  output logic [WORD_W-1:0]  rx_word,
  output logic               sh_start,
  output logic [BYTE_W-1:0]  sh_byte,
  input  logic               sh_done,
  input  logic [BYTE_W-1:0]  sh_rx,
  output logic               busy,
  output logic               done_flag,
  output logic               ovf_flag
);
  localparam int RW = BURST_W + 1;
  localparam logic [RW-1:0] BYTE_BITS = RW'(BYTE_W);

  ctrl_state_e        state;
  logic [RW-1:0]      rem, sum, burst_rnd, eff_rem;
  logic [WORD_W-1:0]  word_q, acc_q;
  logic [2:0]         left_q, nbytes;
  logic               burst_end;

  always_comb begin
    sum       = RW'(burst_m1) + BYTE_BITS;
    burst_rnd = {sum[RW-1:3], 3'b000};
    eff_rem   = (rem == '0) ? burst_rnd : rem;
    nbytes    = (eff_rem[4:3] == 2'b00) ? 3'd4 : {1'b0, eff_rem[4:3]};
    burst_end = (rem == '0);
  end

  always_comb begin
    case (left_q)
      3'd4:    sh_byte = word_q[31:24];
      3'd3:    sh_byte = word_q[23:16];
      3'd2:    sh_byte = word_q[15:8];
      default: sh_byte = word_q[7:0];
    endcase
  end

  assign tx_take  = (state == ST_IDLE) && busy && tx_avail;
  assign sh_start = (state == ST_SEND);
  assign rx_put   = (state == ST_STORE) && rx_space;
  assign rx_word  = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rem       <= '0;
      word_q    <= '0;
      acc_q     <= '0;
      left_q    <= '0;
      busy      <= 1'b0;
      done_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (busy) begin
            if (tx_avail) begin
              word_q <= tx_word;
              rem    <= eff_rem;
              left_q <= nbytes;
              acc_q  <= '0;
              state  <= ST_SEND;
            end else begin
              done_flag <= 1'b1;
              busy      <= 1'b0;
            end
          end
        end
        ST_SEND: state <= ST_WAIT;
        ST_WAIT: begin
          if (sh_done) begin
            acc_q <= {acc_q[WORD_W-BYTE_W-1:0], sh_rx};
            rem   <= rem - BYTE_BITS;
            if (left_q == 3'd1) begin
              state <= ST_STORE;
            end else begin
              left_q <= left_q - 1'b1;
              state  <= ST_SEND;
            end
          end
        end
        ST_STORE: begin
          if (!rx_space) ovf_flag <= 1'b1;
          if ((burst_end && !multi) || !tx_avail) begin
            done_flag <= 1'b1;
            busy      <= 1'b0;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (start) begin
        busy      <= 1'b1;
        done_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_burst_xchg.sv
module spi_burst_xchg
  import spi_burst_pkg::*;
#(
  parameter int BURST_W    = 12,
  parameter int FIFO_DEPTH = 64,
  parameter int SCLK_HALF  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BURST_W-1:0] cfg_burst_len,
  input  logic               cfg_multi,
  input  logic               xch_start,
  output logic               xch_busy,
  output logic               xfer_done,
  output logic               rx_overflow,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [31:0]        tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [31:0]        rx_data,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso
);
  logic              q_avail, q_take, r_space, r_put, sh_start, sh_done;
  logic [WORD_W-1:0] q_word, r_word;
  logic [BYTE_W-1:0] sh_byte, sh_rx;

  sbx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(q_avail), .out_ready(q_take), .out_data(q_word)
  );

  sbx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(r_put), .in_ready(r_space), .in_data(r_word),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  sbx_ctrl #(.BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .burst_m1(cfg_burst_len), .multi(cfg_multi), .start(xch_start),
    .tx_avail(q_avail), .tx_word(q_word), .tx_take(q_take),
    .rx_space(r_space), .rx_put(r_put), .rx_word(r_word),
    .sh_start(sh_start), .sh_byte(sh_byte), .sh_done(sh_done), .sh_rx(sh_rx),
    .busy(xch_busy), .done_flag(xfer_done), .ovf_flag(rx_overflow)
  );

  sbx_shifter #(.SCLK_HALF(SCLK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(sh_start), .tx_byte(sh_byte), .rx_byte(sh_rx), .done(sh_done),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );
endmodule

// File: rtl/spi_burst_xchg_chk.sv
module spi_burst_xchg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xch_start,
  input logic        xch_busy,
  input logic        xfer_done,
  input logic        rx_overflow,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [31:0] rx_data,
  input logic        sclk,
  input logic        mosi
);
  assert_mosi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xch_busy |-> !sclk);

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> rx_overflow);

  assert_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xch_start |=> (xch_busy && !xfer_done));

  assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xch_busy) |-> xfer_done);

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind spi_burst_xchg spi_burst_xchg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xch_start(xch_start), .xch_busy(xch_busy),
  .xfer_done(xfer_done), .rx_overflow(rx_overflow), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .sclk(sclk), .mosi(mosi)
);

// File: tb/spi_burst_xchg_tb.sv
module spi_burst_xchg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_burst_len = '0;
  logic        cfg_multi = 1'b0;
  logic        xch_start = 1'b0;
  logic        xch_busy, xfer_done, rx_overflow;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [31:0] rx_data;
  logic        sclk, mosi, miso;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0]  exp_mosi[$];
  logic [31:0] exp_rx[$];

  always #4 clk = ~clk;
  assign miso = ~mosi;

  spi_burst_xchg #(.BURST_W(12), .FIFO_DEPTH(8), .SCLK_HALF(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_len(cfg_burst_len), .cfg_multi(cfg_multi),
    .xch_start(xch_start), .xch_busy(xch_busy), .xfer_done(xfer_done),
    .rx_overflow(rx_overflow), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: rebuild MOSI bytes at SCLK rising edges, compare with scoreboard
  logic [7:0] mon_byte = '0;
  int         mon_bits = 0;
  always @(posedge sclk) begin
    mon_byte = {mon_byte[6:0], mosi};
    mon_bits++;
    if (mon_bits == 8) begin
      mon_bits = 0;
      if (exp_mosi.size() == 0) check(1'b0, "R3 unexpected MOSI byte", {24'h0, mon_byte}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_mosi.pop_front();
        check(mon_byte == e, "R3 MOSI byte order", {24'h0, mon_byte}, {24'h0, e});
      end
    end
  end

  // Driver side: queue what a word of nbits must produce
  task automatic expect_word(input logic [31:0] w, input int nbits, input bit stored);
    logic [31:0] mask;
    for (int k = nbits / 8 - 1; k >= 0; k--) exp_mosi.push_back(w[k*8 +: 8]);
    mask = (nbits == 32) ? 32'hFFFF_FFFF : ((32'h1 << nbits) - 1);
    if (stored) exp_rx.push_back(~w & mask);
  endtask

  task automatic push_tx(input logic [31:0] w);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = w;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic start_xch();
    @(negedge clk);
    xch_start = 1'b1;
    @(negedge clk);
    xch_start = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    while (xch_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(xfer_done == 1'b1, {tag, " done flag"}, {31'h0, xfer_done}, 32'h1);
    check(sclk == 1'b0, "R9 SCLK idles low", {31'h0, sclk}, 32'h0);
    check(exp_mosi.size() == 0, {tag, " all bytes sent"}, exp_mosi.size(), 32'h0);
  endtask

  task automatic drain_rx(input string tag);
    while (exp_rx.size() != 0) begin
      logic [31:0] e;
      @(negedge clk);
      e = exp_rx.pop_front();
      check(rx_valid == 1'b1, {tag, " rx word present"}, {31'h0, rx_valid}, 32'h1);
      check(rx_data == e, {tag, " R4 rx word"}, rx_data, e);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
    @(negedge clk);
    check(rx_valid == 1'b0, {tag, " R10 rx empty"}, {31'h0, rx_valid}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check({xch_busy, xfer_done, rx_overflow, rx_valid, sclk} == 5'b0, "R11 reset flags",
          {27'h0, xch_busy, xfer_done, rx_overflow, rx_valid, sclk}, 32'h0);
    check(tx_ready == 1'b1, "R11 tx_ready after reset", {31'h0, tx_ready}, 32'h1);

    // R3/R4/R7: one 32-bit word
    cfg_burst_len = 12'd31;
    expect_word(32'hA1B2_C3D4, 32, 1'b1);
    push_tx(32'hA1B2_C3D4);
    start_xch();
    wait_idle("R7");
    check(xch_busy == 1'b0, "R7 busy cleared", {31'h0, xch_busy}, 32'h0);
    drain_rx("R4");

    // R1/R6: 12 bits round to 16; second word stays queued
    cfg_burst_len = 12'd11;
    expect_word(32'h7777_BEEF, 16, 1'b1);
    push_tx(32'h7777_BEEF);
    push_tx(32'h0000_1234);
    start_xch();
    wait_idle("R1 R6");
    drain_rx("R1");
    expect_word(32'h0000_1234, 16, 1'b1);
    start_xch();
    wait_idle("R6 leftover");
    drain_rx("R6");

    // R2: 40-bit burst, first word partial
    cfg_burst_len = 12'd39;
    expect_word(32'h1234_56AB, 8, 1'b1);
    expect_word(32'hCAFE_F00D, 32, 1'b1);
    push_tx(32'h1234_56AB);
    push_tx(32'hCAFE_F00D);
    start_xch();
    wait_idle("R2");
    drain_rx("R2");

    // R8: multi-burst, two 40-bit bursts back to back
    cfg_multi = 1'b1;
    expect_word(32'h0000_00C3, 8, 1'b1);
    expect_word(32'h89AB_CDEF, 32, 1'b1);
    expect_word(32'hFFFF_FF18, 8, 1'b1);
    expect_word(32'h0F1E_2D3C, 32, 1'b1);
    push_tx(32'h0000_00C3);
    push_tx(32'h89AB_CDEF);
    push_tx(32'hFFFF_FF18);
    push_tx(32'h0F1E_2D3C);
    start_xch();
    wait_idle("R8");
    drain_rx("R8");

    // R10: fill transmit FIFO, offer one more while full
    cfg_burst_len = 12'd7;
    for (int i = 0; i < 8; i++) begin
      push_tx(32'h0000_0040 + i);
      expect_word(32'h0000_0040 + i, 8, 1'b1);
    end
    @(negedge clk);
    check(tx_ready == 1'b0, "R10 tx_ready low when full", {31'h0, tx_ready}, 32'h0);
    tx_valid = 1'b1;
    tx_data  = 32'h0000_0099;
    @(negedge clk);
    tx_valid = 1'b0;
    start_xch();
    wait_idle("R10");
    check(rx_overflow == 1'b0, "R5 no overflow yet", {31'h0, rx_overflow}, 32'h0);

    // R5: receive FIFO full, next word dropped
    expect_word(32'h0000_005A, 8, 1'b0);
    push_tx(32'h0000_005A);
    start_xch();
    wait_idle("R5");
    check(rx_overflow == 1'b1, "R5 overflow set", {31'h0, rx_overflow}, 32'h1);
    drain_rx("R5");
    check(rx_overflow == 1'b1, "R5 overflow sticky", {31'h0, rx_overflow}, 32'h1);

    // R12: start clears done and sets busy; empty FIFO ends at once (R7)
    @(negedge clk);
    xch_start = 1'b1;
    @(negedge clk);
    xch_start = 1'b0;
    check(xch_busy == 1'b1, "R12 busy after start", {31'h0, xch_busy}, 32'h1);
    check(xfer_done == 1'b0, "R12 done cleared", {31'h0, xfer_done}, 32'h0);
    wait_idle("R7 empty start");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule